// File: doc/BRIEF.md
# Home-Node Coherence Directory Controller

This block sits at the home node of a shared-memory multiprocessor and keeps the caches coherent for the memory blocks it owns. It does not broadcast. For each block it records a coherence state and a presence vector with one bit per processor. It sends point-to-point messages only to the processors that the vector names. Caches send it read misses, write misses and write-backs of dirty data. It answers with data replies, invalidations, and fetch or fetch-and-invalidate recalls addressed to the current owner. It also keeps a local copy of every block's data.

The controller handles one request at a time and holds `req_ready` low from acceptance until the final data reply has been sent. Outgoing messages appear one per cycle on a single valid-qualified channel with no backpressure. When an owner is recalled, it returns the block on the `fetch_*` inputs, and the controller writes that data to its memory before it replies.

Top module: `coh_home_dir`

## Requirements
- R1: After reset every block is Uncached with an empty presence vector and zero data, `req_ready` is high and `msg_valid` is low.
- R2: A read miss (req_op 0) on an Uncached block produces exactly one data reply (msg_op 0) to the requester with the stored data. The block becomes Shared with only the requester present.
- R3: A read miss on a Shared block produces one data reply and adds the requester to the presence vector, with no other message.
- R4: A write miss (req_op 1) on an Uncached block produces one data reply and leaves the block Exclusive, owned by the requester.
- R5: A write miss on a Shared block first sends one invalidate (msg_op 1) per present processor other than the requester, one per cycle in ascending processor index, then the data reply. The block becomes Exclusive, owned by the requester.
- R6: A read miss on an Exclusive block sends a fetch (msg_op 2) to the owner and waits for `fetch_valid`. It stores the returned data, replies with that data, and leaves the block Shared with both owner and requester present.
- R7: A write miss on an Exclusive block sends a fetch-and-invalidate (msg_op 3) to the owner, stores and replies with the returned data, and leaves the block Exclusive, owned by the requester only.
- R8: A write-back (req_op 2) from the owner of an Exclusive block stores its data, makes the block Uncached with no processor present, and sends no message.
- R9: A write-back from a processor that does not own the block, or to a block that is not Exclusive, sends no message and changes neither data nor directory state.
- R10: `req_ready` is low from the cycle after a read or write miss is accepted until the cycle after its data reply, and it is high again right after the reply.
- R11: Every message carries the block number of the request being served, and directory state is kept separately per block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting a request |
| req_op | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_src | input | $clog2(NPROC) | Requesting processor |
| req_blk | input | $clog2(NBLK) | Block number |
| req_data | input | DW | Write-back data |
| fetch_valid | input | 1 | Owner returns recalled block |
| fetch_data | input | DW | Recalled block data |
| msg_valid | output | 1 | Outgoing message valid this cycle |
| msg_op | output | 2 | 0 data reply, 1 invalidate, 2 fetch, 3 fetch-and-invalidate |
| msg_dst | output | $clog2(NPROC) | Destination processor |
| msg_blk | output | $clog2(NBLK) | Block number |
| msg_data | output | DW | Reply data (zero for other messages) |

## Verification
The bench targets a write miss on a Shared block whose sharers include the requester. A design that got this wrong would invalidate the requester itself, send the invalidates out of index order, or skip the non-adjacent sharers. A read miss on an Exclusive block must leave the old owner present. Later write misses check this: a design that dropped the owner would send one invalidate too few. Write-backs from non-owners and to Uncached blocks must leave data untouched, so the following replies catch a design that stored them. Recalls check that the reply carries the freshly returned data and not the stale memory copy.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;

  typedef enum logic [1:0] {
    DIR_UNC = 2'd0,
    DIR_SHR = 2'd1,
    DIR_EXC = 2'd2
  } dir_state_e;

  typedef enum logic [2:0] {
    HC_IDLE   = 3'd0,
    HC_INV    = 3'd1,
    HC_RECALL = 3'd2,
    HC_WAIT   = 3'd3,
    HC_REPLY  = 3'd4
  } hc_state_e;

  localparam logic [1:0] REQ_READ  = 2'd0;
  localparam logic [1:0] REQ_WRITE = 2'd1;
  localparam logic [1:0] REQ_WBACK = 2'd2;

  localparam logic [1:0] MSG_DATA      = 2'd0;
  localparam logic [1:0] MSG_INV       = 2'd1;
  localparam logic [1:0] MSG_FETCH     = 2'd2;
  localparam logic [1:0] MSG_FETCH_INV = 2'd3;

endpackage

// File: rtl/coh_low_pick.sv
module coh_low_pick #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = i[IW-1:0];
    end
  end
endmodule

// File: rtl/coh_dir_table.sv
module coh_dir_table
  import coh_dir_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NBLK  = 8,
  localparam int BW   = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BW-1:0]    rd_blk,
  output dir_state_e       rd_state,
  output logic [NPROC-1:0] rd_shr,
  input  logic             wr_en,
  input  logic [BW-1:0]    wr_blk,
  input  dir_state_e       wr_state,
  input  logic [NPROC-1:0] wr_shr
);
  dir_state_e       st_q  [NBLK];
  logic [NPROC-1:0] shr_q [NBLK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBLK; b++) begin
        st_q[b]  <= DIR_UNC;
        shr_q[b] <= '0;
      end
    end else if (wr_en) begin
      st_q[wr_blk]  <= wr_state;
      shr_q[wr_blk] <= wr_shr;
    end
  end

  assign rd_state = st_q[rd_blk];
  assign rd_shr   = shr_q[rd_blk];

  for (genvar b = 0; b < NBLK; b++) begin : g_chk
    // R7: an Exclusive block has exactly one holder
    a_r7_excl_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
      st_q[b] == DIR_EXC |-> $countones(shr_q[b]) == 1);
    // R8: an Uncached block has no holder
    a_r8_unc_empty: assert property (@(posedge clk) disable iff (!rst_n)
      st_q[b] == DIR_UNC |-> shr_q[b] == '0);
  end
endmodule

// File: rtl/coh_blk_mem.sv
module coh_blk_mem #(
  parameter int NBLK = 8,
  parameter int DW   = 32,
  localparam int BW  = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] rd_blk,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [BW-1:0] wr_blk,
  input  logic [DW-1:0] wr_data
);
  logic [DW-1:0] mem_q [NBLK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBLK; b++) mem_q[b] <= '0;
    end else if (wr_en) begin
      mem_q[wr_blk] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_blk];
endmodule

// File: rtl/coh_home_dir.sv
module coh_home_dir
  import coh_dir_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NBLK  = 8,
  parameter int DW    = 32,
  localparam int PW   = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int BW   = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [PW-1:0] req_src,
  input  logic [BW-1:0] req_blk,
  input  logic [DW-1:0] req_data,
  input  logic          fetch_valid,
  input  logic [DW-1:0] fetch_data,
  output logic          msg_valid,
  output logic [1:0]    msg_op,
  output logic [PW-1:0] msg_dst,
  output logic [BW-1:0] msg_blk,
  output logic [DW-1:0] msg_data
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  hc_state_e        st_q, st_d;
  logic [1:0]       op_q;
  logic [PW-1:0]    src_q;
  logic [BW-1:0]    blk_q;
  dir_state_e       old_st_q;
  logic [NPROC-1:0] old_shr_q;
  logic [NPROC-1:0] pend_q, pend_d;
  logic             lat_en;

  logic [BW-1:0]    rd_blk;
  dir_state_e       dir_st;
  logic [NPROC-1:0] dir_shr;
  logic             dir_we;
  dir_state_e       dir_wst;
  logic [NPROC-1:0] dir_wshr;

  logic [DW-1:0]    mem_rdata;
  logic             mem_we;
  logic [BW-1:0]    mem_wblk;
  logic [DW-1:0]    mem_wdata;

  logic             pend_found, own_found;
  logic [PW-1:0]    pend_idx, own_idx;
  logic [NPROC-1:0] src_1h, req_1h, pick_1h;
  logic             accept, wb_ok;

  assign rd_blk = (st_q == HC_IDLE) ? req_blk : blk_q;

  coh_dir_table #(.NPROC(NPROC), .NBLK(NBLK)) u_dir (
    .clk(clk), .rst_n(rst_i_n), .rd_blk(rd_blk), .rd_state(dir_st), .rd_shr(dir_shr),
    .wr_en(dir_we), .wr_blk(blk_wr_sel()), .wr_state(dir_wst), .wr_shr(dir_wshr)
  );

  coh_blk_mem #(.NBLK(NBLK), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_i_n), .rd_blk(rd_blk), .rd_data(mem_rdata),
    .wr_en(mem_we), .wr_blk(mem_wblk), .wr_data(mem_wdata)
  );

  coh_low_pick #(.N(NPROC)) u_pend_pick (.vec(pend_q), .found(pend_found), .idx(pend_idx));
  coh_low_pick #(.N(NPROC)) u_own_pick  (.vec(old_shr_q), .found(own_found), .idx(own_idx));

  function automatic logic [BW-1:0] blk_wr_sel();
    return (st_q == HC_IDLE) ? req_blk : blk_q;
  endfunction

  always_comb begin
    src_1h  = '0; src_1h[src_q]   = 1'b1;
    req_1h  = '0; req_1h[req_src] = 1'b1;
    pick_1h = '0; pick_1h[pend_idx] = pend_found;
  end

  assign req_ready = (st_q == HC_IDLE);
  assign accept    = req_valid && req_ready;
  assign wb_ok     = (dir_st == DIR_EXC) && dir_shr[req_src];

  // next-state logic
  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    lat_en = 1'b0;
    unique case (st_q)
      HC_IDLE: begin
        if (accept && req_op != REQ_WBACK) begin
          lat_en = 1'b1;
          pend_d = '0;
          if (dir_st == DIR_EXC) begin
            st_d = HC_RECALL;
          end else if (req_op == REQ_WRITE && dir_st == DIR_SHR &&
                       (dir_shr & ~req_1h) != '0) begin
            pend_d = dir_shr & ~req_1h;
            st_d   = HC_INV;
          end else begin
            st_d = HC_REPLY;
          end
        end
      end
      HC_INV: begin
        pend_d = pend_q & ~pick_1h;
        if (pend_d == '0) st_d = HC_REPLY;
      end
      HC_RECALL: st_d = HC_WAIT;
      HC_WAIT:   if (fetch_valid) st_d = HC_REPLY;
      HC_REPLY:  st_d = HC_IDLE;
      default:   st_d = HC_IDLE;
    endcase
  end

  // directory and memory write selection
  always_comb begin
    dir_we    = 1'b0;
    dir_wst   = DIR_UNC;
    dir_wshr  = '0;
    mem_we    = 1'b0;
    mem_wblk  = blk_q;
    mem_wdata = fetch_data;
    if (st_q == HC_IDLE && accept && req_op == REQ_WBACK && wb_ok) begin
      dir_we    = 1'b1;
      mem_we    = 1'b1;
      mem_wblk  = req_blk;
      mem_wdata = req_data;
    end else if (st_q == HC_WAIT && fetch_valid) begin
      mem_we = 1'b1;
    end else if (st_q == HC_REPLY) begin
      dir_we = 1'b1;
      if (op_q == REQ_READ) begin
        dir_wst  = DIR_SHR;
        dir_wshr = (old_st_q == DIR_UNC) ? src_1h : (old_shr_q | src_1h);
      end else begin
        dir_wst  = DIR_EXC;
        dir_wshr = src_1h;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= HC_IDLE;
      pend_q <= '0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      op_q      <= REQ_READ;
      src_q     <= '0;
      blk_q     <= '0;
      old_st_q  <= DIR_UNC;
      old_shr_q <= '0;
    end else if (lat_en) begin
      op_q      <= req_op;
      src_q     <= req_src;
      blk_q     <= req_blk;
      old_st_q  <= dir_st;
      old_shr_q <= dir_shr;
    end
  end

  // outgoing message
  always_comb begin
    msg_valid = 1'b0;
    msg_op    = MSG_DATA;
    msg_dst   = src_q;
    msg_blk   = blk_q;
    msg_data  = '0;
    unique case (st_q)
      HC_INV: begin
        msg_valid = pend_found;
        msg_op    = MSG_INV;
        msg_dst   = pend_idx;
      end
      HC_RECALL: begin
        msg_valid = own_found;
        msg_op    = (op_q == REQ_WRITE) ? MSG_FETCH_INV : MSG_FETCH;
        msg_dst   = own_idx;
      end
      HC_REPLY: begin
        msg_valid = 1'b1;
        msg_data  = mem_rdata;
      end
      default: ;
    endcase
  end

  // R10: the cycle after a data reply the controller accepts again
  a_r10_reply_frees: assert property (@(posedge clk) disable iff (!rst_i_n)
    msg_valid && msg_op == MSG_DATA |=> req_ready);
  // R10: an accepted miss makes the controller busy
  a_r10_busy_after_miss: assert property (@(posedge clk) disable iff (!rst_i_n)
    accept && req_op != REQ_WBACK |=> !req_ready);
  // R8, R9: write-backs never produce a message
  a_r8_wb_silent: assert property (@(posedge clk) disable iff (!rst_i_n)
    accept && req_op == REQ_WBACK |=> !msg_valid);
  // R6, R7: after a recall the controller stays silent while it waits
  a_r6_recall_quiet: assert property (@(posedge clk) disable iff (!rst_i_n)
    msg_valid && (msg_op == MSG_FETCH || msg_op == MSG_FETCH_INV) |=> !msg_valid);
  // R5: each invalidate retires exactly one pending sharer
  a_r5_inv_drops_one: assert property (@(posedge clk) disable iff (!rst_i_n)
    st_q == HC_INV |=> $countones(pend_q) == $countones($past(pend_q)) - 1);
  // R5: the requester is never invalidated
  a_r5_inv_not_self: assert property (@(posedge clk) disable iff (!rst_i_n)
    msg_valid && msg_op == MSG_INV |-> msg_dst != src_q);
endmodule

// File: tb/coh_home_dir_test.sv
module coh_home_dir_test;
  localparam int NPROC = 4;
  localparam int NBLK  = 8;
  localparam int DW    = 32;

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  dst;
    logic [2:0]  blk;
    logic [31:0] data;
    logic [7:0]  rq;
  } exp_t;

  logic clk, rst_n;
  logic req_valid, req_ready;
  logic [1:0] req_op;
  logic [1:0] req_src;
  logic [2:0] req_blk;
  logic [31:0] req_data;
  logic fetch_valid;
  logic [31:0] fetch_data;
  logic msg_valid;
  logic [1:0] msg_op;
  logic [1:0] msg_dst;
  logic [2:0] msg_blk;
  logic [31:0] msg_data;

  int errors = 0;
  int checks = 0;
  int unexp  = 0;
  exp_t exp_q[$];
  exp_t cur;
  logic [31:0] fetch_ret;

  coh_home_dir #(.NPROC(NPROC), .NBLK(NBLK), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_src(req_src), .req_blk(req_blk), .req_data(req_data),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data), .msg_valid(msg_valid),
    .msg_op(msg_op), .msg_dst(msg_dst), .msg_blk(msg_blk), .msg_data(msg_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic expect_msg(input logic [1:0] op, input logic [1:0] dst, input logic [2:0] blk,
                            input logic [31:0] data, input int rq);
    exp_q.push_back('{op: op, dst: dst, blk: blk, data: data, rq: rq[7:0]});
  endtask

  // monitor: compares every message with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && msg_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        unexp++;
        $display("FAIL unexpected message actual=op%0d dst%0d blk%0d data %h expected=none",
                 msg_op, msg_dst, msg_blk, msg_data);
      end else begin
        cur = exp_q.pop_front();
        if (msg_op !== cur.op || msg_dst !== cur.dst || msg_blk !== cur.blk || msg_data !== cur.data) begin
          errors++;
          $display("FAIL R%0d message actual=op%0d dst%0d blk%0d data %h expected=op%0d dst%0d blk%0d data %h",
                   cur.rq, msg_op, msg_dst, msg_blk, msg_data, cur.op, cur.dst, cur.blk, cur.data);
        end
      end
    end
  end

  // owner cache model: answers a recall one cycle after seeing it
  initial begin
    fetch_valid = 1'b0;
    fetch_data  = '0;
    forever begin
      @(negedge clk);
      if (rst_n && msg_valid && msg_op >= 2'd2) begin
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_data  = fetch_ret;
        @(negedge clk);
        fetch_valid = 1'b0;
      end
    end
  end

  task automatic send(input logic [1:0] op, input logic [1:0] src, input logic [2:0] blk,
                      input logic [31:0] data, input bit chk_busy);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_src = src; req_blk = blk; req_data = data;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    // R10: busy right after accepting a miss
    if (chk_busy) check(req_ready == 1'b0, "R10 busy after accept", {31'd0, req_ready}, 32'd0);
    for (int i = 0; i < 40; i++) begin
      if (exp_q.size() == 0 && req_ready) break;
      @(negedge clk);
    end
    // R10: free again after the reply
    check(req_ready == 1'b1 && exp_q.size() == 0, "R10 idle after request",
          {31'd0, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int u0;
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_src = '0; req_blk = '0; req_data = '0;
    fetch_ret = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset outputs
    check(req_ready == 1'b1, "R1 ready after reset", {31'd0, req_ready}, 32'd1);
    check(msg_valid == 1'b0, "R1 no message after reset", {31'd0, msg_valid}, 32'd0);

    // R2, R1: read miss on Uncached block 3, zero data
    expect_msg(2'd0, 2'd1, 3'd3, 32'd0, 2);
    send(2'd0, 2'd1, 3'd3, 32'd0, 1);
    // R3: more readers join
    expect_msg(2'd0, 2'd3, 3'd3, 32'd0, 3);
    send(2'd0, 2'd3, 3'd3, 32'd0, 0);
    expect_msg(2'd0, 2'd0, 3'd3, 32'd0, 3);
    send(2'd0, 2'd0, 3'd3, 32'd0, 0);
    // R5: write miss by a sharer: invalidate 0 then 1, not 3
    expect_msg(2'd1, 2'd0, 3'd3, 32'd0, 5);
    expect_msg(2'd1, 2'd1, 3'd3, 32'd0, 5);
    expect_msg(2'd0, 2'd3, 3'd3, 32'd0, 5);
    send(2'd1, 2'd3, 3'd3, 32'd0, 1);
    // R9: write-back from non-owner 1 ignored
    u0 = unexp;
    send(2'd2, 2'd1, 3'd3, 32'h0000_0055, 0);
    check(unexp == u0, "R9 non-owner write-back silent", unexp, u0);
    // R8: owner 3 writes back
    u0 = unexp;
    send(2'd2, 2'd3, 3'd3, 32'hAAAA_0003, 0);
    check(unexp == u0, "R8 owner write-back silent", unexp, u0);
    // R4, R8, R9: block now Uncached holding owner data, so only a reply
    expect_msg(2'd0, 2'd2, 3'd3, 32'hAAAA_0003, 4);
    send(2'd1, 2'd2, 3'd3, 32'd0, 0);
    // R6: read miss on Exclusive (owner 2)
    fetch_ret = 32'h1234_5678;
    expect_msg(2'd2, 2'd2, 3'd3, 32'd0, 6);
    expect_msg(2'd0, 2'd0, 3'd3, 32'h1234_5678, 6);
    send(2'd0, 2'd0, 3'd3, 32'd0, 1);
    // R6, R5: old owner 2 still a sharer next to 0
    expect_msg(2'd1, 2'd0, 3'd3, 32'd0, 6);
    expect_msg(2'd1, 2'd2, 3'd3, 32'd0, 6);
    expect_msg(2'd0, 2'd1, 3'd3, 32'h1234_5678, 5);
    send(2'd1, 2'd1, 3'd3, 32'd0, 0);
    // R7: write miss on Exclusive (owner 1)
    fetch_ret = 32'hCAFE_0001;
    expect_msg(2'd3, 2'd1, 3'd3, 32'd0, 7);
    expect_msg(2'd0, 2'd0, 3'd3, 32'hCAFE_0001, 7);
    send(2'd1, 2'd0, 3'd3, 32'd0, 0);
    // R7: only requester 0 owns it now
    fetch_ret = 32'h0BAD_F00D;
    expect_msg(2'd2, 2'd0, 3'd3, 32'd0, 7);
    expect_msg(2'd0, 2'd2, 3'd3, 32'h0BAD_F00D, 7);
    send(2'd0, 2'd2, 3'd3, 32'd0, 0);
    // R9: write-back to an Uncached block ignored, R11: other block untouched
    u0 = unexp;
    send(2'd2, 2'd1, 3'd5, 32'hDEAD_BEEF, 0);
    check(unexp == u0, "R9 write-back to Uncached silent", unexp, u0);
    expect_msg(2'd0, 2'd1, 3'd5, 32'd0, 9);
    send(2'd0, 2'd1, 3'd5, 32'd0, 0);
    // R11: block 7 independent of block 3 state
    expect_msg(2'd0, 2'd2, 3'd7, 32'd0, 11);
    send(2'd1, 2'd2, 3'd7, 32'd0, 0);
    // R4: write miss with requester alone in Shared gives reply only
    expect_msg(2'd0, 2'd1, 3'd5, 32'd0, 4);
    send(2'd1, 2'd1, 3'd5, 32'd0, 0);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R11 scoreboard drained", exp_q.size(), 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule